// File: doc/BRIEF.md
# Interrupt Pending and Enable Controller

This block gathers interrupt requests from the sources of an audio subsystem into a single 32-bit pending word. A 32-bit enable word masks that word onto one active-high interrupt line. Each source raises its bit with a one-cycle event pulse. Software clears bits by writing ones to the pending word.

Each of the 64 voice channels also has two flags of its own: one for a full-loop event and one for a half-loop event. Together these form four 32-bit loop registers. Whenever any of these flags is set, a summary bit in the pending word goes high, and the low six bits of the pending word report the highest channel with a flag set. To clear one channel's flags, software writes that channel's index back with the summary bit set.

Accesses use a plain register port. A write is a one-cycle strobe with a select and data. A read presents a select, and the data appears one clock later. The interrupt line is registered and follows the internal state one clock later.

Top module: `irq_ctrl`

## Requirements
- R1: After a synchronous reset, these all read zero: the pending word, the enable word, all four loop registers, the read data and the interrupt line.
- R2: An event pulse on `src_evt[i]`, for i from 7 to 31, sets pending bit i. The bit then holds until software clears it.
- R3: A write to select 0 (pending) clears every pending bit in [31:7] whose data bit is 1. Bits written with 0 keep their value.
- R4: If an event and a clear hit the same pending bit or channel flag in the same cycle, the event wins and the bit stays set.
- R5: Pending bit 6 reads 1 exactly when any full-loop or half-loop flag is set. Bits [5:0] then read the highest such channel number, 0 to 63, and read 0 when no flag is set.
- R6: Select 2 reads the full-loop flags of channels 0 to 31 and select 3 those of channels 32 to 63. Selects 4 and 5 read the half-loop flags in the same way. Bit n of each register stands for the channel (n, or n+32 for the upper half).
- R7: A write to select 0 with data bit 6 set clears both the full-loop and the half-loop flag of the channel given in data[5:0]. A write with bit 6 at 0 clears no channel flag.
- R8: One cycle after the state changes, the interrupt line equals the OR of three terms: any pending bit in [31:7] whose enable bit is set, the summary bit when enable bit 6 is set, and the force bit.
- R9: Enable bit 0 is a force bit. While it is 1, the interrupt line is held high, whatever the pending state.
- R10: A write to select 1 stores the enable word, and a read of select 1 returns it.
- R11: Event pulses on `src_evt[6:0]` have no effect. Writes to selects 2 to 7 have no effect, and reads of selects 6 and 7 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write register select |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Read register select |
| rd_data | output | 32 | Registered read data, valid one cycle after `rd_sel` |
| src_evt | input | 32 | Source event pulses, bits [31:7] used |
| full_evt | input | 64 | Per-channel full-loop event pulses |
| half_evt | input | 64 | Per-channel half-loop event pulses |
| irq | output | 1 | Registered interrupt request |

## Verification
On every cycle, the assertions check four things: a source event leaves its pending bit set, a write-one clear empties the bits it targets unless an event coincides, an index clear removes that channel's two flags, and the force bit raises the interrupt on the next cycle. They also check that the reported channel has a flag set and that no higher channel does. Other behaviours need the bench's scenarios to show them. These include the exact bits [5:0] reported after a series of index clears, and the tie between the two flags of one channel. They also include the masking of the summary bit by its enable, and the fact that a write without bit 6 leaves the channel flags alone.

// File: rtl/irq_ctrl_pkg.sv
package irq_ctrl_pkg;
  typedef enum logic [2:0] {
    SEL_PEND    = 3'd0,
    SEL_ENAB    = 3'd1,
    SEL_FULL_LO = 3'd2,
    SEL_FULL_HI = 3'd3,
    SEL_HALF_LO = 3'd4,
    SEL_HALF_HI = 3'd5
  } reg_sel_e;

  localparam int FORCE_BIT = 0;
endpackage

// File: rtl/irq_src_bank.sv
module irq_src_bank #(
  parameter int W  = 32,
  parameter int LO = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] evt,
  input  logic         clr_en,
  input  logic [W-1:0] clr_mask,
  output logic [W-1:0] pend
);
  localparam logic [W-1:0] KEEP = {W{1'b1}} << LO;

  logic [W-1:0] pend_q;
  logic [W-1:0] kill;

  always_comb kill = clr_en ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= ((pend_q & ~kill) | evt) & KEEP;
  end

  assign pend = pend_q;

  // an event always lands in its pending bit
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (|(evt & KEEP)) |=> ((pend_q & $past(evt & KEEP)) == $past(evt & KEEP)));

  // a clear empties targeted bits unless an event coincides (R4)
  assert_w1c_R3: assert property (@(posedge clk) disable iff (rst)
    clr_en |=> ((pend_q & $past(clr_mask & ~evt & KEEP)) == '0));
endmodule

// File: rtl/irq_loop_bank.sv
module irq_loop_bank #(
  parameter int NUM_CH = 64,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [NUM_CH-1:0] full_evt,
  input  logic [NUM_CH-1:0] half_evt,
  input  logic              clr_en,
  input  logic [IDX_W-1:0]  clr_idx,
  output logic [NUM_CH-1:0] full_q,
  output logic [NUM_CH-1:0] half_q
);
  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
    logic hit;
    always_comb hit = clr_en && (clr_idx == IDX_W'(ch));
    always_ff @(posedge clk) begin
      if (rst) begin
        full_q[ch] <= 1'b0;
        half_q[ch] <= 1'b0;
      end else begin
        full_q[ch] <= full_evt[ch] | (full_q[ch] & ~hit);
        half_q[ch] <= half_evt[ch] | (half_q[ch] & ~hit);
      end
    end
  end

  assert_idx_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (clr_en && !full_evt[clr_idx] && !half_evt[clr_idx])
      |=> (!full_q[$past(clr_idx)] && !half_q[$past(clr_idx)]));
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int N  = 64,
  parameter int IW = 6
) (
  input  logic [N-1:0]  vec,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = 0; i < N; i++) begin
      if (vec[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_ctrl_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  logic [2:0]          wr_sel,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic [2:0]          rd_sel,
  output logic [DATA_W-1:0]   rd_data,
  input  logic [DATA_W-1:0]   src_evt,
  input  logic [2*DATA_W-1:0] full_evt,
  input  logic [2*DATA_W-1:0] half_evt,
  output logic                irq
);
  localparam int NUM_CH   = 2 * DATA_W;
  localparam int IDX_W    = $clog2(NUM_CH);
  localparam int LOOP_BIT = IDX_W;
  localparam int SRC_LO   = IDX_W + 1;

  logic [DATA_W-1:0] enab_q;
  logic [DATA_W-1:0] src_pend;
  logic [NUM_CH-1:0] full_q, half_q, loop_or;
  logic              loop_any;
  logic [IDX_W-1:0]  loop_idx;
  logic              pend_wr;
  logic [DATA_W-1:0] pend_word;
  logic [DATA_W-1:0] rd_next;

  always_comb pend_wr = wr_en && (reg_sel_e'(wr_sel) == SEL_PEND);

  irq_src_bank #(.W(DATA_W), .LO(SRC_LO)) u_src (
    .clk(clk), .rst(rst), .evt(src_evt),
    .clr_en(pend_wr), .clr_mask(wr_data), .pend(src_pend)
  );

  irq_loop_bank #(.NUM_CH(NUM_CH), .IDX_W(IDX_W)) u_loop (
    .clk(clk), .rst(rst), .full_evt(full_evt), .half_evt(half_evt),
    .clr_en(pend_wr && wr_data[LOOP_BIT]), .clr_idx(wr_data[IDX_W-1:0]),
    .full_q(full_q), .half_q(half_q)
  );

  always_comb loop_or = full_q | half_q;

  irq_prio_enc #(.N(NUM_CH), .IW(IDX_W)) u_enc (
    .vec(loop_or), .any(loop_any), .idx(loop_idx)
  );

  always_comb begin
    pend_word = src_pend;
    pend_word[LOOP_BIT] = loop_any;
    pend_word[IDX_W-1:0] = loop_any ? loop_idx : '0;
  end

  always_ff @(posedge clk) begin
    if (rst) enab_q <= '0;
    else if (wr_en && reg_sel_e'(wr_sel) == SEL_ENAB) enab_q <= wr_data;
  end

  always_comb begin
    case (reg_sel_e'(rd_sel))
      SEL_PEND:    rd_next = pend_word;
      SEL_ENAB:    rd_next = enab_q;
      SEL_FULL_LO: rd_next = full_q[DATA_W-1:0];
      SEL_FULL_HI: rd_next = full_q[NUM_CH-1:DATA_W];
      SEL_HALF_LO: rd_next = half_q[DATA_W-1:0];
      SEL_HALF_HI: rd_next = half_q[NUM_CH-1:DATA_W];
      default:     rd_next = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
      irq     <= 1'b0;
    end else begin
      rd_data <= rd_next;
      irq     <= (|(src_pend & enab_q)) | (loop_any & enab_q[LOOP_BIT])
                 | enab_q[FORCE_BIT];
    end
  end

  assert_force_R9: assert property (@(posedge clk) disable iff (rst)
    enab_q[FORCE_BIT] |=> irq);

  assert_top_channel_R5: assert property (@(posedge clk) disable iff (rst)
    loop_any |-> (loop_or[loop_idx] && (((loop_or >> loop_idx) >> 1) == '0)));

  assert_no_loop_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (loop_or == '0) |-> !loop_any);
endmodule

// File: tb/irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module irq_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        wr_en;
  logic [2:0]  wr_sel;
  logic [31:0] wr_data;
  logic [2:0]  rd_sel;
  logic [31:0] rd_data;
  logic [31:0] src_evt;
  logic [63:0] full_evt, half_evt;
  logic        irq;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  irq_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_sel(rd_sel), .rd_data(rd_data), .src_evt(src_evt),
    .full_evt(full_evt), .half_evt(half_evt), .irq(irq)
  );

  // stimulus table: {event word, clear word}
  localparam int NV = 6;
  localparam logic [63:0] VEC [NV] = '{
    {32'h0000_0200, 32'h0000_0000},
    {32'h0000_C080, 32'h0000_0000},
    {32'h0000_0000, 32'h0000_0200},
    {32'h8000_0000, 32'h0000_4000},
    {32'h0000_007F, 32'h0000_0000},
    {32'h0000_0000, 32'hFFFF_FF80}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic pulse(input logic [31:0] se, input logic [63:0] fe, input logic [63:0] he,
                       input logic we, input logic [2:0] ws, input logic [31:0] wd);
    src_evt = se; full_evt = fe; half_evt = he;
    wr_en = we; wr_sel = ws; wr_data = wd;
    @(negedge clk);
    src_evt = '0; full_evt = '0; half_evt = '0; wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [31:0] v);
    rd_sel = s;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic wreg(input logic [2:0] s, input logic [31:0] d);
    pulse('0, '0, '0, 1'b1, s, d);
  endtask

  initial begin
    logic [31:0] v;
    logic [31:0] model;
    rst = 1'b1; wr_en = 1'b0; wr_sel = '0; wr_data = '0; rd_sel = '0;
    src_evt = '0; full_evt = '0; half_evt = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    check("R1 rd_data", rd_data, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    for (int s = 0; s < 6; s++) begin
      rd(3'(s), v);
      check($sformatf("R1 reg %0d", s), v, 32'h0);
    end

    // table walk, enable word zero
    model = '0;
    for (int k = 0; k < NV; k++) begin
      pulse(VEC[k][63:32], '0, '0, 1'b0, 3'd0, '0);
      wreg(3'd0, VEC[k][31:0]);
      model = (model | (VEC[k][63:32] & 32'hFFFF_FF80)) & ~VEC[k][31:0];
      rd(3'd0, v);
      check($sformatf("R2,R3,R11 vec %0d", k), v, model);
      check("R8 irq masked", {31'b0, irq}, 32'h0);
    end

    // R4 same-cycle event and clear
    pulse(32'h0000_0200, '0, '0, 1'b1, 3'd0, 32'h0000_0200);
    rd(3'd0, v); check("R4 event beats clear", v, 32'h0000_0200);

    // R8 / R10 enable
    wreg(3'd1, 32'h0000_0200);
    rd(3'd1, v); check("R10 enable readback", v, 32'h0000_0200);
    check("R8 irq enabled source", {31'b0, irq}, 32'h1);
    wreg(3'd1, 32'h0000_0400);
    rd(3'd0, v); check("R8 irq other enable", {31'b0, irq}, 32'h0);
    wreg(3'd0, 32'h0000_0200);

    // loop flags: full ch5, half ch40
    pulse('0, 64'd1 << 5, 64'd1 << 40, 1'b0, 3'd0, '0);
    rd(3'd0, v); check("R5 highest channel 40", v, 32'h0000_0068);
    check("R8 loop flag gated off", {31'b0, irq}, 32'h0);
    rd(3'd2, v); check("R6 full lo", v, 32'h0000_0020);
    rd(3'd3, v); check("R6 full hi", v, 32'h0);
    rd(3'd4, v); check("R6 half lo", v, 32'h0);
    rd(3'd5, v); check("R6 half hi", v, 32'h0000_0100);
    wreg(3'd1, 32'h0000_0040);
    rd(3'd0, v); check("R8 loop flag enabled", {31'b0, irq}, 32'h1);

    wreg(3'd0, 32'h0000_0005);
    rd(3'd0, v); check("R7 no clear without bit 6", v, 32'h0000_0068);
    wreg(3'd0, 32'h0000_0068);
    rd(3'd0, v); check("R7 clear ch40", v, 32'h0000_0045);
    rd(3'd5, v); check("R7 half hi empty", v, 32'h0);
    wreg(3'd0, 32'h0000_0045);
    rd(3'd0, v); check("R5 no flag reads zero", v, 32'h0);
    check("R8 irq drops", {31'b0, irq}, 32'h0);

    // tie on ch63, plus half ch2
    pulse('0, 64'd1 << 63, (64'd1 << 63) | 64'd4, 1'b0, 3'd0, '0);
    rd(3'd0, v); check("R5 channel 63", v, 32'h0000_007F);
    wreg(3'd0, 32'h0000_007F);
    rd(3'd0, v); check("R7 both flags of ch63", v, 32'h0000_0042);
    rd(3'd3, v); check("R7 full hi empty", v, 32'h0);
    rd(3'd4, v); check("R6 half lo ch2", v, 32'h0000_0004);
    wreg(3'd0, 32'h0000_0042);

    // loop event and index clear together
    pulse('0, 64'd1 << 10, '0, 1'b1, 3'd0, 32'h0000_004A);
    rd(3'd0, v); check("R4 loop event beats clear", v, 32'h0000_004A);
    wreg(3'd0, 32'h0000_004A);
    rd(3'd0, v); check("R7 ch10 cleared", v, 32'h0);

    // force
    wreg(3'd1, 32'h0000_0001);
    rd(3'd1, v); check("R10 force readback", v, 32'h0000_0001);
    check("R9 force irq", {31'b0, irq}, 32'h1);

    // ignored accesses
    wreg(3'd2, 32'hFFFF_FFFF);
    rd(3'd2, v); check("R11 write sel 2 ignored", v, 32'h0);
    rd(3'd6, v); check("R11 sel 6 reads zero", v, 32'h0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule